// File: doc/BRIEF.md
# I2C Read-Only Register Array Target

This block is an I2C target that holds a byte-addressed array and serves reads from it through an internal address pointer. A controller can read from wherever the pointer currently stands. It can also do a random read: a write phase carries one word address, which loads the pointer, and a repeated START then opens a read. In either case the controller may keep acknowledging to stream consecutive bytes. The pointer walks through every address bit and wraps from the top location back to zero.

The bus is seen as two sampled inputs, SCL and SDA, which pass through a short synchronizer inside the block. The target pulls SDA low through a single open-drain enable. The 7-bit device address is a parameter. The contents of the array are loaded through a preload write port. The pointer clears to zero at reset, so a bare read issued right after reset dumps the array from address 0 upward.

Top module: `i2c_reg_reader`

## Requirements
- R1: After reset the SDA drive enable is low and the pointer is 0, so the first read after reset returns array[0], array[1], ... in order.
- R2: The target acknowledges an address byte (drives SDA low in the ninth clock) only when its upper 7 bits equal DEV_ADDR; bit 0 is R/W with 1 meaning read. On a mismatch it never drives SDA until the next START, and the pointer is unchanged.
- R3: In a write phase, the byte after an acknowledged address byte is the word address. It is acknowledged and loaded into the pointer, and a read after a repeated START returns array[word address] first.
- R4: Every data byte the target transmits advances the pointer by one at its ninth clock, so a current-address read following a read that ended at location n returns array[n+1].
- R5: When the controller acknowledges (SDA low) a data byte, the target sends the next byte. When it does not (SDA high), the target releases SDA and stays idle; a STOP always releases SDA.
- R6: The pointer increments across all AW bits and wraps from 2**AW-1 to 0 with no gap in the stream.
- R7: Data bits are sent MSB first. The SDA drive enable changes only while SCL is low, and it asserts only just after a falling SCL edge.
- R8: A START or STOP received in the middle of a byte aborts the transfer and leaves the pointer at its value from the last completed operation. A START then begins a new address byte.
- R9: In a write phase, any byte after the word address is not acknowledged and leaves the array unchanged.
- R10: A write on the preload port (pre_we_i high) stores pre_data_i at pre_addr_i, and later reads return the stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | AW | Preload address |
| pre_data_i | input | 8 | Preload data byte |

## Verification
The bench builds the block with its defaults: AW=8, which gives 256 locations, DEV_ADDR=7'h52 and two synchronizer stages. With 256 locations, a random read placed at 254 crosses the wrap within a four-byte stream. It also makes the reset-to-zero dump and the n+1 current-address rule easy to follow through a reference pointer. Random word addresses and stream lengths are mixed with directed cases: a wrong device address, aborts in the middle of a byte by STOP and by repeated START, an extra write byte, and a preload overwrite.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } rd_state_e;
endpackage

// File: rtl/i2c_rd_bus_mon.sv
module i2c_rd_bus_mon #(
  parameter int unsigned SYNC_STG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_s, sda_s, scl_q, sda_q;

  generate
    if (SYNC_STG == 0) begin : g_nosync
      assign scl_s = scl_i;
      assign sda_s = sda_i;
    end else begin : g_sync
      logic [SYNC_STG-1:0] scl_sr, sda_sr;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr[0] <= scl_i;
          sda_sr[0] <= sda_i;
          for (int i = 1; i < int'(SYNC_STG); i++) begin
            scl_sr[i] <= scl_sr[i-1];
            sda_sr[i] <= sda_sr[i-1];
          end
        end
      end
      assign scl_s = scl_sr[SYNC_STG-1];
      assign sda_s = sda_sr[SYNC_STG-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_o   = scl_s;
  assign sda_o   = sda_s;
  assign start_o = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise_o  = scl_s & ~scl_q;
  assign fall_o  = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_rd_array.sv
module i2c_rd_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [AW-1:0]     ptr_o,
  output logic              sda_oe_o,
  output logic              ptr_inc_o,
  output logic              ptr_load_o,
  output rd_state_e         state_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  rd_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, mack_q;
  logic [AW-1:0]     ptr_q;
  logic              bus_evt, byte_rx;

  assign bus_evt    = start_i | stop_i;
  assign byte_rx    = fall_i && (cnt_q == CNT_FULL);
  assign ptr_inc_o  = !bus_evt && (state_q == ST_TX_ACK) && rise_i;
  // word address taken only from a complete byte
  assign ptr_load_o = !bus_evt && (state_q == ST_WADDR) && byte_rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      ptr_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WADDR: begin
          if (rise_i && cnt_q != CNT_FULL) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_rx) begin
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                state_q <= ST_ADDR_ACK;
                rw_q    <= sh_q[0];
              end else begin
                state_q <= ST_IGNORE;
              end
            end else begin
              ptr_q   <= sh_q[AW-1:0];
              state_q <= ST_WADDR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              sh_q    <= rdata_i;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK: begin
          // further write bytes are not acknowledged
          if (fall_i) state_q <= ST_IGNORE;
        end
        ST_TX: begin
          if (fall_i) begin
            if (cnt_q == CNT_LAST) begin
              state_q <= ST_TX_ACK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TX_ACK: begin
          if (rise_i) begin
            mack_q <= ~sda_i;
            ptr_q  <= ptr_q + 1'b1;
          end else if (fall_i) begin
            if (mack_q) begin
              sh_q    <= rdata_i;
              cnt_q   <= '0;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = (state_q == ST_ADDR_ACK) || (state_q == ST_WADDR_ACK) ||
                    (state_q == ST_TX && !sh_q[BYTE_W-1]);
  assign ptr_o    = ptr_q;
  assign state_o  = state_q;
endmodule

// File: rtl/i2c_reg_reader.sv
module i2c_reg_reader
  import i2c_rd_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h52,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              pre_we_i,
  input  logic [AW-1:0]     pre_addr_i,
  input  logic [BYTE_W-1:0] pre_data_i
);
  logic              scl_s, sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] rdata;
  logic              ptr_inc, ptr_load;
  rd_state_e         state;

  i2c_rd_bus_mon #(.SYNC_STG(SYNC_STG)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .scl_o  (scl_s),
    .sda_o  (sda_s),
    .start_o(start_evt),
    .stop_o (stop_evt),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  i2c_rd_array #(.AW(AW), .DW(BYTE_W)) u_arr (
    .clk_i  (clk_i),
    .we_i   (pre_we_i),
    .waddr_i(pre_addr_i),
    .wdata_i(pre_data_i),
    .raddr_i(ptr),
    .rdata_o(rdata)
  );

  i2c_rd_ctrl #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_s),
    .start_i   (start_evt),
    .stop_i    (stop_evt),
    .rise_i    (scl_rise),
    .fall_i    (scl_fall),
    .rdata_i   (rdata),
    .ptr_o     (ptr),
    .sda_oe_o  (sda_oe_o),
    .ptr_inc_o (ptr_inc),
    .ptr_load_o(ptr_load),
    .state_o   (state)
  );

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/i2c_reg_reader_chk.sv
module i2c_reg_reader_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          stop_evt,
  input logic          scl_fall,
  input logic          ptr_inc,
  input logic          ptr_load,
  input logic [AW-1:0] ptr
);
  // R7: drive only moves while SCL is low
  assert_oe_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R7: drive asserts only right after a falling SCL edge
  assert_oe_after_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  // R5: STOP releases SDA
  assert_stop_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_oe_o);

  // R6: increment wraps modulo 2**AW
  assert_ptr_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_inc |=> ptr == AW'($past(ptr) + 1'b1));

  // R8: pointer holds without a completed operation
  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_inc && !ptr_load |=> $stable(ptr));
endmodule

bind i2c_reg_reader i2c_reg_reader_chk #(.AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_i   (scl_i),
  .sda_oe_o(sda_oe_o),
  .stop_evt(stop_evt),
  .scl_fall(scl_fall),
  .ptr_inc (ptr_inc),
  .ptr_load(ptr_load),
  .ptr     (ptr)
);

// File: tb/i2c_reg_reader_tb.sv
module i2c_reg_reader_tb;
  localparam int unsigned AW = 8;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [6:0] DEV = 7'h52;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_bus;
  logic sda_oe;
  logic pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0] pre_data = '0;

  int n_chk = 0, n_fail = 0, oe_viol = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [DEPTH];
  int ref_ptr = 0;

  always #2.5 clk = ~clk;

  assign sda_bus = ~(sda_oe | m_low);

  i2c_reg_reader u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .pre_we_i  (pre_we),
    .pre_addr_i(pre_addr),
    .pre_data_i(pre_data)
  );

  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_ni && m_scl && prev_scl && sda_oe != prev_oe) oe_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; qw();
    m_scl = 1'b1; qw();
    m_low = 1'b1; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qw();
    m_scl = 1'b1; qw();
    m_low = 1'b0; qw();
  endtask

  task automatic wr_bit(input bit b);
    m_low = ~b; qw();
    m_scl = 1'b1; qw(); qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic rd_bit(output bit b);
    m_low = 1'b0; qw();
    m_scl = 1'b1; qw();
    b = sda_bus; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic wr_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wr_bit(d[i]);
    rd_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input bit m_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      d[i] = b;
    end
    wr_bit(~m_ack);
  endtask

  // read phase after a START: device address with R/W=1, then n bytes
  task automatic read_body(input int n, input string req);
    bit ack;
    logic [7:0] d;
    wr_byte({DEV, 1'b1}, ack);
    chk(ack, "R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(d, i != n - 1);
      chk(d == ref_mem[ref_ptr], req, d, ref_mem[ref_ptr]); // R7 MSB first
      ref_ptr = (ref_ptr + 1) % DEPTH;
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R5 released after NACK/STOP", sda_oe, 0);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    bit ack;
    bus_start();
    wr_byte({DEV, 1'b0}, ack);
    chk(ack, "R3 write address ack", ack, 1);
    wr_byte(a, ack);
    chk(ack, "R3 word address ack", ack, 1);
    ref_ptr = a;
    bus_start();
    read_body(n, req);
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
    ref_mem[a] = d;
  endtask

  initial begin
    bit ack, b;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < int'(DEPTH); i++) preload(8'(i), 8'($urandom));
    qw();
    chk(sda_oe == 1'b0, "R1 reset drive released", sda_oe, 0);

    // R1: bare read after reset streams from 0
    bus_start();
    read_body(4, "R1 stream from zero");

    // R4: current address continues at n+1
    bus_start();
    read_body(1, "R4 current address n+1");

    // R2: wrong device address, no drive, pointer untouched
    bus_start();
    wr_byte({DEV ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R2 mismatch not acked", ack, 0);
    wr_byte(8'h00, ack);
    chk(!ack, "R2 mismatch ignores data", ack, 0);
    for (int i = 0; i < 4; i++) begin
      rd_bit(b);
      chk(b == 1'b1, "R2 mismatch SDA released", b, 1);
    end
    bus_stop();
    bus_start();
    read_body(1, "R2 pointer unchanged after mismatch");

    // R3/R5: random reads with random stream length
    for (int k = 0; k < 16; k++)
      rand_read(8'($urandom), 1 + int'($urandom % 4), "R3 random/sequential read data");

    // R6: wrap at top of array
    rand_read(8'd254, 4, "R6 wrap 255 to 0");
    bus_start();
    read_body(2, "R6 continue after wrap");

    // R8: STOP mid word address
    bus_start();
    wr_byte({DEV, 1'b0}, ack);
    for (int i = 0; i < 4; i++) wr_bit(1'b1);
    bus_stop();
    bus_start();
    read_body(1, "R8 STOP abort keeps pointer");

    // R8: repeated START mid word address
    bus_start();
    wr_byte({DEV, 1'b0}, ack);
    for (int i = 0; i < 3; i++) wr_bit(1'b0);
    bus_start();
    read_body(2, "R8 START abort keeps pointer");

    // R9: extra write byte refused, array unchanged
    bus_start();
    wr_byte({DEV, 1'b0}, ack);
    wr_byte(8'h40, ack);
    chk(ack, "R9 word address ack", ack, 1);
    wr_byte(~ref_mem[8'h40], ack);
    chk(!ack, "R9 extra byte not acked", ack, 0);
    bus_stop();
    rand_read(8'h40, 1, "R9 array unchanged");

    // R10: preload overwrite visible to reads
    preload(8'h77, 8'h3C);
    rand_read(8'h77, 1, "R10 preload data");

    chk(oe_viol == 0, "R7 drive change with SCL high", oe_viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule